// File: doc/BRIEF.md
# UART FIFO Interrupt Controller

This block raises the interrupts of a UART that buffers data in receive and transmit FIFOs of sixteen entries. It does not hold the FIFO storage or any serial logic. It keeps the fill count of both FIFOs from strobes: byte arrival, a receive-data read, a transmit-data write and the transmitter taking a byte. From those counts it derives three interrupt sources. The first is a fill-level receive source with a programmable trigger point. The second is a receive-timeout source that catches bytes left below that trigger. The third is a transmit-space source that stays set until it is cleared.

Software reaches the block over a small 8-bit register bus with eight addresses. Reading the data address returns the byte at the head of the receive FIFO and pops it. The smallest receive trigger is two entries, so a single trailing byte never reaches it. That byte is delivered by the timeout source, which counts bit-period ticks while the line stays idle. A per-byte error status, occupancy flags, a mask register, raw and masked status and a write-one-to-clear register complete the interface. The single interrupt output is registered.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset, the raw status (address 5) reads 0, the mask (address 4) reads 0, `irq` is low, and the level select register (address 3) reads 0x12 (receive code 2 in bits 2:0, transmit code 2 in bits 5:3).
- R2: Raw bit 0 (receive) is high exactly while the receive count is at least the trigger chosen by bits 2:0 of address 3. Codes 0, 1, 2, 3 and 4 select 2, 4, 8, 12 and 14 entries, and codes 5 to 7 select 14. One stored byte never sets it.
- R3: A read of address 0 returns `rxHeadData`, pulses `rxPop` and lowers the receive count by one when the FIFO is not empty. An empty FIFO gives no pop, and raw bit 0 falls once the count drops below the trigger.
- R4: Raw bit 1 (timeout) sets on the 32nd `bitTick` counted while the receive FIFO is not empty. A byte arrival or a data read restarts that count.
- R5: Raw bit 1 clears when the receive FIFO becomes empty or when bit 1 is written to address 7. After that it does not set again until a new byte arrives and 32 more ticks pass.
- R6: Raw bit 2 (transmit) sets when `txPop` takes the transmit count from the threshold plus one down to the threshold. The threshold uses the same codes as R2, in bits 5:3 of address 3. The bit then stays set until bit 2 is written to address 7.
- R7: `irq` equals the OR of raw status ANDed with the mask, one clock later. Address 6 reads raw ANDed with the mask, with raw bits 0, 1 and 2 enabled by mask bits 0, 1 and 2.
- R8: Each data read ORs `rxHeadErr` into the error status (address 1, bits 3:0). Writing ones to address 1 clears those bits.
- R9: The flags at address 2 are: bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full. A byte arriving at a full receive FIFO is dropped.
- R10: A write to address 0 pulses `txPush` with `txPushData` equal to the written byte when the transmit FIFO is not full, and no pulse when it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One pulse per serial bit period |
| rxByteValid | input | 1 | A received byte enters the receive FIFO |
| rxHeadData | input | 8 | Byte at the head of the receive FIFO |
| rxHeadErr | input | 4 | Error flags of the head byte |
| txPop | input | 1 | Transmitter takes one byte from the transmit FIFO |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| rxPop | output | 1 | Pops the receive FIFO head |
| txPush | output | 1 | Pushes a byte into the transmit FIFO |
| txPushData | output | 8 | Byte to push |
| irq | output | 1 | Registered combined interrupt |

## Verification
The hardest case to reach is the timeout firing exactly on the 32nd idle tick after a restart. It is just as hard to show that the timeout stays quiet after a clear until a fresh byte arrives, even when a data read comes in between. Directed sequences hold the receive trigger at 14 so that the level source stays out of the way. They count ticks to 31 and then to 32 around a byte arrival, a clear and a data read, and check the raw bit at each point. Random push and read traffic over random trigger codes then checks the level source and the flags against a count kept in the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    ADDR_DATA   = 3'd0,
    ADDR_ERR    = 3'd1,
    ADDR_FLAGS  = 3'd2,
    ADDR_LEVEL  = 3'd3,
    ADDR_MASK   = 3'd4,
    ADDR_RAW    = 3'd5,
    ADDR_MASKED = 3'd6,
    ADDR_CLEAR  = 3'd7
  } regAddr_e;

  localparam int SRC_RX  = 0;
  localparam int SRC_TO  = 1;
  localparam int SRC_TX  = 2;
  localparam int NUM_SRC = 3;
  localparam int ERR_W   = 4;
  localparam int REG_W   = 8;

  typedef struct packed {
    logic               rxPop;
    logic               txPush;
    logic [NUM_SRC-1:0] rawClr;
    logic [ERR_W-1:0]   errClr;
  } ifStrobe_t;

endpackage

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int TIMEOUT_BITS = 32,
  localparam int LVL_W       = $clog2(DEPTH + 1),
  localparam int CNT_W       = $clog2(TIMEOUT_BITS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitTick,
  input  logic               rxByteValid,
  input  logic               txPop,
  input  logic [ERR_W-1:0]   rxHeadErr,
  input  ifStrobe_t          strobe,
  input  logic [LVL_W-1:0]   rxTrig,
  input  logic [LVL_W-1:0]   txTrig,
  output logic [LVL_W-1:0]   rxLevel,
  output logic [LVL_W-1:0]   txLevel,
  output logic [NUM_SRC-1:0] rawStat,
  output logic [ERR_W-1:0]   errStat
);

  logic             rxPush, txPopOk;
  logic [LVL_W-1:0] rxNext, txNext;
  logic [CNT_W-1:0] idleCnt;
  logic             armed, toRaw, txRaw, fireNow;

  assign rxPush  = rxByteValid && (rxLevel != LVL_W'(DEPTH));
  assign txPopOk = txPop && (txLevel != '0);
  assign rxNext  = rxLevel + LVL_W'(rxPush) - LVL_W'(strobe.rxPop);
  assign txNext  = txLevel + LVL_W'(strobe.txPush) - LVL_W'(txPopOk);
  assign fireNow = armed && bitTick && !rxPush && !strobe.rxPop && (rxLevel != '0)
                   && (idleCnt == CNT_W'(TIMEOUT_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxLevel <= '0;
      txLevel <= '0;
      errStat <= '0;
    end else begin
      rxLevel <= rxNext;
      txLevel <= txNext;
      errStat <= (errStat & ~strobe.errClr) | (strobe.rxPop ? rxHeadErr : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
      armed   <= 1'b0;
      toRaw   <= 1'b0;
    end else begin
      if (rxPush) armed <= 1'b1;
      else if (fireNow) armed <= 1'b0;
      if (rxNext == '0 || rxPush || strobe.rxPop || fireNow) idleCnt <= '0;
      else if (armed && bitTick) idleCnt <= idleCnt + CNT_W'(1);
      if (rxNext == '0 || strobe.rawClr[SRC_TO]) toRaw <= 1'b0;
      else if (fireNow) toRaw <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txRaw <= 1'b0;
    else if (txPopOk && txLevel > txTrig && txNext <= txTrig) txRaw <= 1'b1;
    else if (strobe.rawClr[SRC_TX]) txRaw <= 1'b0;
  end

  assign rawStat[SRC_RX] = rxLevel >= rxTrig;
  assign rawStat[SRC_TO] = toRaw;
  assign rawStat[SRC_TX] = txRaw;

  // R9
  rx_level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxLevel <= LVL_W'(DEPTH));
  // R5
  to_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    toRaw |-> rxLevel != '0);
  // R4
  to_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toRaw) |-> $past(bitTick));
  // R6
  tx_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txRaw) |-> $past(txPop));
  // R3
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rxPop && !rxPush) |=> rxLevel == $past(rxLevel) - LVL_W'(1));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regAddr,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [7:0]         rxHeadData,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [NUM_SRC-1:0] rawStat,
  input  logic [ERR_W-1:0]   errStat,
  output logic [REG_W-1:0]   regRdData,
  output ifStrobe_t          strobe,
  output logic [LVL_W-1:0]   rxTrig,
  output logic [LVL_W-1:0]   txTrig,
  output logic               irq
);

  logic [NUM_SRC-1:0] mask;
  logic [2:0]         rxCode, txCode;
  logic               rxEmpty, rxFull, txEmpty, txFull;
  regAddr_e           addr;

  function automatic logic [LVL_W-1:0] trigOf(input logic [2:0] code);
    case (code)
      3'd0:    return LVL_W'(2);
      3'd1:    return LVL_W'(4);
      3'd2:    return LVL_W'(DEPTH / 2);
      3'd3:    return LVL_W'((DEPTH * 3) / 4);
      default: return LVL_W'(DEPTH - 2);
    endcase
  endfunction

  assign addr    = regAddr_e'(regAddr);
  assign rxEmpty = rxLevel == '0;
  assign rxFull  = rxLevel == LVL_W'(DEPTH);
  assign txEmpty = txLevel == '0;
  assign txFull  = txLevel == LVL_W'(DEPTH);
  assign rxTrig  = trigOf(rxCode);
  assign txTrig  = trigOf(txCode);

  always_comb begin
    strobe        = '0;
    strobe.rxPop  = regRd && addr == ADDR_DATA && !rxEmpty;
    strobe.txPush = regWr && addr == ADDR_DATA && !txFull;
    if (regWr && addr == ADDR_CLEAR) strobe.rawClr = regWrData[NUM_SRC-1:0];
    if (regWr && addr == ADDR_ERR)   strobe.errClr = regWrData[ERR_W-1:0];
  end

  always_comb begin
    case (addr)
      ADDR_DATA:   regRdData = rxHeadData;
      ADDR_ERR:    regRdData = REG_W'(errStat);
      ADDR_FLAGS:  regRdData = REG_W'({txFull, txEmpty, rxFull, rxEmpty});
      ADDR_LEVEL:  regRdData = REG_W'({txCode, rxCode});
      ADDR_MASK:   regRdData = REG_W'(mask);
      ADDR_RAW:    regRdData = REG_W'(rawStat);
      ADDR_MASKED: regRdData = REG_W'(rawStat & mask);
      default:     regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask   <= '0;
      rxCode <= 3'd2;
      txCode <= 3'd2;
      irq    <= 1'b0;
    end else begin
      if (regWr && addr == ADDR_MASK) mask <= regWrData[NUM_SRC-1:0];
      if (regWr && addr == ADDR_LEVEL) begin
        rxCode <= regWrData[2:0];
        txCode <= regWrData[5:3];
      end
      irq <= |(rawStat & mask);
    end
  end

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == $past(|(rawStat & mask)));
  // R10
  push_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txPush |-> txLevel < LVL_W'(DEPTH));

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_irq_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int TIMEOUT_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       rxByteValid,
  input  logic [7:0] rxHeadData,
  input  logic [3:0] rxHeadErr,
  input  logic       txPop,
  input  logic [2:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       rxPop,
  output logic       txPush,
  output logic [7:0] txPushData,
  output logic       irq
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  ifStrobe_t          strobe;
  logic [LVL_W-1:0]   rxLevel, txLevel, rxTrig, txTrig;
  logic [NUM_SRC-1:0] rawStat;
  logic [ERR_W-1:0]   errStat;

  uart_irq_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .rxHeadData(rxHeadData), .rxLevel(rxLevel),
    .txLevel(txLevel), .rawStat(rawStat), .errStat(errStat),
    .regRdData(regRdData), .strobe(strobe), .rxTrig(rxTrig), .txTrig(txTrig),
    .irq(irq)
  );

  uart_irq_datapath #(.DEPTH(DEPTH), .TIMEOUT_BITS(TIMEOUT_BITS)) dpath (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxByteValid(rxByteValid),
    .txPop(txPop), .rxHeadErr(rxHeadErr), .strobe(strobe), .rxTrig(rxTrig),
    .txTrig(txTrig), .rxLevel(rxLevel), .txLevel(txLevel), .rawStat(rawStat),
    .errStat(errStat)
  );

  assign rxPop      = strobe.rxPop;
  assign txPush     = strobe.txPush;
  assign txPushData = regWrData;

endmodule

// File: tb/uart_fifo_irq_test.sv
`timescale 1ns/1ps
module uart_fifo_irq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0, rxByteValid = 1'b0, txPop = 1'b0;
  logic [7:0] rxHeadData = 8'h00;
  logic [3:0] rxHeadErr = 4'h0;
  logic [2:0] regAddr = 3'd0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData, txPushData;
  logic       rxPop, txPush, irq;

  int errors = 0, checks = 0;
  logic lastPop, lastPush;
  logic [7:0] lastPushData;

  always #2 clk = ~clk;

  uart_fifo_irq uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxByteValid(rxByteValid),
    .rxHeadData(rxHeadData), .rxHeadErr(rxHeadErr), .txPop(txPop),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWrData(regWrData),
    .regRdData(regRdData), .rxPop(rxPop), .txPush(txPush),
    .txPushData(txPushData), .irq(irq)
  );

  function automatic int trigOf(input int code);
    case (code)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 12;
      default: return 14;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWr = 1'b1; regWrData = d;
    #1; lastPush = txPush; lastPushData = txPushData;
    @(posedge clk); #1; regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a; regRd = 1'b1;
    #1; d = regRdData; lastPop = rxPop;
    @(posedge clk); #1; regRd = 1'b0;
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      rxByteValid = 1'b1; @(posedge clk); #1; rxByteValid = 1'b0;
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1; @(posedge clk); #1; bitTick = 1'b0;
    end
  endtask

  task automatic pop(input int n);
    for (int i = 0; i < n; i++) begin
      txPop = 1'b1; @(posedge clk); #1; txPop = 1'b0;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int lvl, code;
    void'($urandom(32'd1234));
    step(3); rstN = 1'b1; #1;

    // R1 reset state
    rd(3'd5, d); check("R1 raw", d, 0);
    rd(3'd4, d); check("R1 mask", d, 0);
    rd(3'd3, d); check("R1 level", d, 8'h12);
    check("R1 irq", irq, 0);
    rd(3'd2, d); check("R9 reset flags", d, 4'b0101);

    // R2 / R3 trigger codes, directed sweep
    for (int c = 0; c < 8; c++) begin
      wr(3'd3, 8'(c) | 8'h10);
      for (int l = 1; l <= 14; l++) begin
        push(1);
        rd(3'd5, d); check("R2 rx level raw", d & 1, (l >= trigOf(c)) ? 1 : 0);
      end
      for (int l = 13; l >= 0; l--) begin
        rxHeadData = 8'($urandom);
        rd(3'd0, d); check("R3 head data", d, rxHeadData);
        rd(3'd5, d); check("R3 raw after pop", d & 1, (l >= trigOf(c)) ? 1 : 0);
      end
    end
    rd(3'd1, d); wr(3'd1, 8'h0F);

    // R9 full, overflow dropped
    push(17);
    rd(3'd2, d); check("R9 rx full flags", d & 3, 2);
    for (int i = 0; i < 16; i++) rd(3'd0, d);
    rd(3'd2, d); check("R9 overflow dropped", d & 1, 1);
    rd(3'd0, d); check("R3 no pop when empty", lastPop, 0);

    // R4 timeout with trigger 14
    wr(3'd3, 8'h14);
    push(1); tick(20); push(1); tick(31);
    rd(3'd5, d); check("R4 quiet at 31", d, 0);
    tick(1);
    rd(3'd5, d); check("R4 fires at 32", d, 2);
    wr(3'd4, 8'h02);
    check("R7 irq registered delay", irq, 0);
    step(1); check("R7 irq", irq, 1);
    rd(3'd6, d); check("R7 masked", d, 2);

    // R5 clear and no re-fire
    wr(3'd7, 8'h02);
    rd(3'd5, d); check("R5 cleared", d, 0);
    tick(40); rd(3'd5, d); check("R5 no refire", d, 0);
    rd(3'd0, d); tick(40); rd(3'd5, d); check("R5 read does not rearm", d, 0);
    push(1); tick(31); rd(3'd5, d); check("R5 rearm 31", d, 0);
    tick(1); rd(3'd5, d); check("R5 rearm 32", d, 2);
    rd(3'd0, d); rd(3'd5, d); check("R5 still set", d, 2);
    rd(3'd0, d); rd(3'd5, d); check("R5 empty clears", d, 0);
    step(1); check("R7 irq low", irq, 0);
    wr(3'd4, 8'h00);

    // R6 / R10 transmit
    for (int i = 0; i < 10; i++) begin
      wr(3'd0, 8'(8'hA0 + i));
      if (i == 0) begin
        check("R10 push", lastPush, 1);
        check("R10 data", lastPushData, 8'hA0);
      end
    end
    pop(1); rd(3'd5, d); check("R6 above thr", d, 0);
    pop(1); rd(3'd5, d); check("R6 crossing", d, 4);
    pop(1); rd(3'd5, d); check("R6 sticky", d, 4);
    wr(3'd7, 8'h04); rd(3'd5, d); check("R6 cleared", d, 0);
    pop(7); rd(3'd5, d); check("R6 no set below", d, 0);
    rd(3'd2, d); check("R9 tx empty", (d >> 2) & 1, 1);
    for (int i = 0; i < 16; i++) wr(3'd0, 8'h55);
    rd(3'd2, d); check("R9 tx full", (d >> 3) & 1, 1);
    wr(3'd0, 8'h66); check("R10 no push when full", lastPush, 0);

    // R8 error status
    push(1); rxHeadErr = 4'b0101; rd(3'd0, d);
    rd(3'd1, d); check("R8 err capture", d, 5);
    push(1); rxHeadErr = 4'b1000; rd(3'd0, d);
    rd(3'd1, d); check("R8 err accumulate", d, 8'hD);
    wr(3'd1, 8'h05); rd(3'd1, d); check("R8 w1c partial", d, 8);
    wr(3'd1, 8'h08); rd(3'd1, d); check("R8 w1c all", d, 0);
    rxHeadErr = 4'h0;

    // R2 / R9 random traffic
    lvl = 0; code = 2;
    wr(3'd3, 8'h12);
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) begin
        push(1); if (lvl < 16) lvl++;
      end else if (op < 8) begin
        rd(3'd0, d); if (lvl > 0) lvl--;
      end else begin
        code = int'($urandom_range(0, 7));
        wr(3'd3, 8'(code) | 8'h10);
      end
      rd(3'd5, d); check("R2 random raw", d & 1, (lvl >= trigOf(code)) ? 1 : 0);
      rd(3'd2, d); check("R9 random flags", d & 3,
                         (lvl == 0 ? 1 : 0) | (lvl == 16 ? 2 : 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule